// File: doc/BRIEF.md
# Configuration Integrity Reset Monitor

This block watches a bank of configuration registers together with a second bank that is meant to hold the bitwise inverse of each word. While the device is running, every bit of every configuration word must differ from the bit at the same place in its shadow word. If any pair of bits is equal, the block treats the configuration as corrupted. It then raises a hard reset request for a fixed minimum time and clears a sticky integrity flag.

The same hard reset request also covers the other hard reset sources, such as an external clear pin, a software reset, a watchdog expiry or a stack fault. None of these sources touches the integrity flag. Whenever a hard reset ends, and once after power-on, the block sends a one-cycle reload strobe so that the configuration is copied in again from nonvolatile storage. Checking stays off until the reload logic reports that both the register bank and the shadow bank have been rewritten.

Software reads the flag at a fixed bit of a status byte. After reading the flag, software may set it back to 1. The flag can only go to 0 through a detected mismatch.

Top module: `cmr_monitor`

## Requirements
- R1: While checking is active, a configuration bit equal to its shadow bit, in any word and at any bit position, drives hard_rst_o high at the next clock edge. Banks that are exact complements never do this, whatever the data pattern.
- R2: A mismatch holds hard_rst_o high for exactly HOLD_CYCLES clock cycles (default 3). If another reset source stays active longer, the request lasts until one edge after that source drops.
- R3: Any bit of rst_src_i at 1 drives hard_rst_o high from the next edge. The request falls at the edge after all source bits are 0, unless a mismatch hold is still running.
- R4: A detected mismatch clears the integrity flag at the same edge at which hard_rst_o rises. The flag appears at bit 5 of stat_o, and all other bits of stat_o read 0.
- R5: The other reset sources leave the integrity flag unchanged.
- R6: Power-on reset sets the flag to 1. A pulse on flag_set_i sets it to 1 at the next edge. A mismatch in the same cycle as flag_set_i wins, and the flag goes to 0.
- R7: rld_o is a single-cycle pulse. It appears in the first cycle after power-on reset is released, and one cycle after hard_rst_o falls. It is never high together with hard_rst_o.
- R8: From the start of any hard reset until both ld_cfg_i and ld_shd_i have been seen after the reload pulse (in either order, or together), no mismatch causes a reset.
- R9: During power-on reset, hard_rst_o and rld_o are 0 and stat_o is 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| cfg_i | input | NUM_WORDS*WORD_W | Configuration register bank, word 0 in the low bits |
| shd_i | input | NUM_WORDS*WORD_W | Shadow bank, expected to be the bitwise inverse of cfg_i |
| ld_cfg_i | input | 1 | Pulse: the reload has rewritten the configuration bank |
| ld_shd_i | input | 1 | Pulse: the reload has rewritten the shadow bank |
| rst_src_i | input | NUM_SRC | Other hard reset sources, active high levels |
| flag_set_i | input | 1 | Software pulse that sets the integrity flag to 1 |
| hard_rst_o | output | 1 | Hard reset request |
| rld_o | output | 1 | One-cycle pulse requesting a configuration reload |
| stat_o | output | STAT_W | Status byte with the integrity flag at bit FLAG_POS |

## Verification
The bench puts single equal bit pairs at the top bit of the last word, the bottom bit of the first word and a bit in a middle word. A comparator that skips a word or checks for equality instead of complement would miss one of these, or would reset on clean data such as all zeros or all ones. It corrupts the shadow bank while only one half of the reload has been reported, which catches a design that starts checking too early and would reset again in a loop. It also raises a flag set and a mismatch in the same cycle, and lets a long external reset overlap the mismatch hold. A wrong priority there leaves the flag at 1, and a wrong merge cuts the reset short or sends the reload strobe while the reset is still active.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
   typedef enum logic [0:0] {
      ST_LOAD = 1'b0,
      ST_RUN  = 1'b1
   } cmr_state_e;
endpackage

// File: rtl/cmr_word_cmp.sv
module cmr_word_cmp #(
   parameter int WORD_W = 8
) (
   input  logic [WORD_W-1:0] cfg_i,
   input  logic [WORD_W-1:0] shd_i,
   output logic              bad_o
);
   // a bit pair is healthy only when the two bits differ
   assign bad_o = |(~(cfg_i ^ shd_i));
endmodule

// File: rtl/cmr_hold_timer.sv
module cmr_hold_timer #(
   parameter int HOLD_CYCLES = 3
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic start_i,
   output logic busy_o
);
   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("HOLD_CYCLES must be at least 1");
   end

   if (HOLD_CYCLES == 1) begin : g_single
      // the edge that sees the mismatch already gives the one required cycle
      assign busy_o = 1'b0;
   end else begin : g_count
      localparam int CNT_W = $clog2(HOLD_CYCLES);
      localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge por_ni) begin
         if (!por_ni) begin
            cnt_q <= '0;
         end else if (start_i) begin
            cnt_q <= LOAD_VAL;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end

      assign busy_o = (cnt_q != '0);

      // R2
      cnt_range_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
         cnt_q <= LOAD_VAL);
      // R2
      cnt_step_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
         (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
   end
endmodule

// File: rtl/cmr_flag.sv
module cmr_flag (
   input  logic clk_i,
   input  logic por_ni,
   input  logic clr_i,
   input  logic set_i,
   output logic flag_o
);
   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) begin
         flag_o <= 1'b1;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end else if (set_i) begin
         flag_o <= 1'b1;
      end
   end

   // R4
   flag_clr_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      clr_i |=> !flag_o);
   // R5
   flag_hold_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      (!clr_i && !set_i) |=> $stable(flag_o));
   // R6
   flag_set_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      (set_i && !clr_i) |=> flag_o);
endmodule

// File: rtl/cmr_monitor.sv
module cmr_monitor #(
   parameter int NUM_WORDS   = 4,
   parameter int WORD_W      = 8,
   parameter int HOLD_CYCLES = 3,
   parameter int NUM_SRC     = 4,
   parameter int STAT_W      = 8,
   parameter int FLAG_POS    = 5,
   parameter bit CMP_REG     = 1'b0
) (
   input  logic                          clk_i,
   input  logic                          por_ni,
   input  logic [NUM_WORDS*WORD_W-1:0]   cfg_i,
   input  logic [NUM_WORDS*WORD_W-1:0]   shd_i,
   input  logic                          ld_cfg_i,
   input  logic                          ld_shd_i,
   input  logic [NUM_SRC-1:0]            rst_src_i,
   input  logic                          flag_set_i,
   output logic                          hard_rst_o,
   output logic                          rld_o,
   output logic [STAT_W-1:0]             stat_o
);
   import cmr_pkg::*;

   if (NUM_WORDS < 1 || WORD_W < 1 || NUM_SRC < 1) begin : g_bad_size
      $error("NUM_WORDS, WORD_W and NUM_SRC must be at least 1");
   end
   if (FLAG_POS < 0 || FLAG_POS >= STAT_W) begin : g_bad_pos
      $error("FLAG_POS must lie inside the status byte");
   end

   cmr_state_e           state_q;
   logic [NUM_WORDS-1:0] word_bad;
   logic                 raw_bad;
   logic                 fire;
   logic                 any_src;
   logic                 hold_busy;
   logic                 rst_next;
   logic                 rst_q;
   logic                 pend_q;
   logic                 rld_q;
   logic                 rld_go;
   logic                 cfg_seen_q;
   logic                 shd_seen_q;
   logic                 cfg_now;
   logic                 shd_now;
   logic                 accept;
   logic                 flag;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      cmr_word_cmp #(.WORD_W(WORD_W)) u_cmp (
         .cfg_i (cfg_i[w*WORD_W +: WORD_W]),
         .shd_i (shd_i[w*WORD_W +: WORD_W]),
         .bad_o (word_bad[w])
      );
   end

   assign raw_bad = |word_bad;

   if (CMP_REG) begin : g_cmp_reg
      logic mism_q;
      always_ff @(posedge clk_i or negedge por_ni) begin
         if (!por_ni) begin
            mism_q <= 1'b0;
         end else begin
            mism_q <= raw_bad && (state_q == ST_RUN);
         end
      end
      assign fire = (state_q == ST_RUN) && mism_q;
   end else begin : g_cmp_comb
      assign fire = (state_q == ST_RUN) && raw_bad;
   end

   assign any_src = |rst_src_i;

   cmr_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk_i   (clk_i),
      .por_ni  (por_ni),
      .start_i (fire),
      .busy_o  (hold_busy)
   );

   assign rst_next = fire | hold_busy | any_src;
   assign rld_go   = pend_q && !rst_q && !rst_next;
   assign accept   = (state_q == ST_LOAD) && !pend_q && !rst_next;
   assign cfg_now  = cfg_seen_q | ld_cfg_i;
   assign shd_now  = shd_seen_q | ld_shd_i;

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) begin
         state_q    <= ST_LOAD;
         rst_q      <= 1'b0;
         pend_q     <= 1'b1;
         rld_q      <= 1'b0;
         cfg_seen_q <= 1'b0;
         shd_seen_q <= 1'b0;
      end else begin
         rst_q <= rst_next;
         rld_q <= rld_go;
         if (rst_next) begin
            pend_q <= 1'b1;
         end else if (rld_go) begin
            pend_q <= 1'b0;
         end
         if (rst_next) begin
            state_q    <= ST_LOAD;
            cfg_seen_q <= 1'b0;
            shd_seen_q <= 1'b0;
         end else if (accept) begin
            if (cfg_now && shd_now) begin
               state_q    <= ST_RUN;
               cfg_seen_q <= 1'b0;
               shd_seen_q <= 1'b0;
            end else begin
               cfg_seen_q <= cfg_now;
               shd_seen_q <= shd_now;
            end
         end
      end
   end

   cmr_flag u_flag (
      .clk_i  (clk_i),
      .por_ni (por_ni),
      .clr_i  (fire),
      .set_i  (flag_set_i),
      .flag_o (flag)
   );

   assign hard_rst_o = rst_q;
   assign rld_o      = rld_q;

   always_comb begin
      stat_o           = '0;
      stat_o[FLAG_POS] = flag;
   end

   // R1
   mism_rst_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      fire |=> hard_rst_o);
   // R3
   src_rst_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      any_src |=> hard_rst_o);
   // R7
   rld_pulse_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      rld_o |=> !rld_o);
   // R7
   rld_quiet_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      rld_o |-> (!hard_rst_o && !$past(hard_rst_o)));
   // R8
   rst_cause_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
      $rose(hard_rst_o) |-> $past(fire || any_src));
endmodule

// File: tb/sim_cmr_monitor.sv
module sim_cmr_monitor;
   localparam int NW = 4;
   localparam int WW = 8;
   localparam int BW = NW * WW;

   typedef struct {
      int    cyc;
      logic  rst;
      logic  rld;
      logic  flag;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic [BW-1:0] cfg = '0;
   logic [BW-1:0] shd = '1;
   logic          ld_cfg = 1'b0;
   logic          ld_shd = 1'b0;
   logic [3:0]    rst_src = '0;
   logic          flag_set = 1'b0;
   logic          hard_rst;
   logic          rld;
   logic [7:0]    stat;

   int   cyc = 0;
   int   n_run = 0;
   int   n_fail = 0;
   exp_t q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cmr_monitor u0 (
      .clk_i      (clk),
      .por_ni     (por_n),
      .cfg_i      (cfg),
      .shd_i      (shd),
      .ld_cfg_i   (ld_cfg),
      .ld_shd_i   (ld_shd),
      .rst_src_i  (rst_src),
      .flag_set_i (flag_set),
      .hard_rst_o (hard_rst),
      .rld_o      (rld),
      .stat_o     (stat)
   );

   // monitor: pops expected items and compares shortly after each edge
   always @(posedge clk) begin
      #1;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         exp_t e;
         logic [7:0] es;
         e  = q.pop_front();
         es = 8'(e.flag) << 5;
         n_run++;
         if (e.cyc < cyc) begin
            n_fail++;
            $display("FAIL %s: item for cycle %0d missed, now %0d", e.tag, e.cyc, cyc);
         end else if (hard_rst !== e.rst || rld !== e.rld || stat !== es) begin
            n_fail++;
            $display("FAIL %s: cyc %0d rst=%0b rld=%0b stat=%02h expected rst=%0b rld=%0b stat=%02h",
                     e.tag, cyc, hard_rst, rld, stat, e.rst, e.rld, es);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_at(input int k, input logic r, input logic l, input logic f,
                            input string tag);
      exp_t e;
      e.cyc = cyc + k; e.rst = r; e.rld = l; e.flag = f; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic good(input logic [BW-1:0] x);
      cfg = x;
      shd = ~x;
   endtask

   task automatic reload(input int order);
      if (order == 0) begin
         ld_cfg = 1'b1; ld_shd = 1'b1; step(1); ld_cfg = 1'b0; ld_shd = 1'b0;
      end else if (order == 1) begin
         ld_cfg = 1'b1; step(1); ld_cfg = 1'b0; ld_shd = 1'b1; step(1); ld_shd = 1'b0;
      end else begin
         ld_shd = 1'b1; step(1); ld_shd = 1'b0; ld_cfg = 1'b1; step(1); ld_cfg = 1'b0;
      end
      step(1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish, expected end before cycle 20000");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      good(32'h0);
      step(2);
      // R9 reset state
      expect_at(1, 0, 0, 1, "R9");
      step(1);

      // R7 reload pulse after power-on
      por_n = 1'b1;
      expect_at(1, 0, 1, 1, "R7");
      expect_at(2, 0, 0, 1, "R7");
      step(1);

      // R8 half-finished reload with corrupt shadow must not reset
      shd = cfg;
      ld_cfg = 1'b1;
      for (int k = 1; k <= 4; k++) expect_at(k, 0, 0, 1, "R8");
      step(1);
      ld_cfg = 1'b0;
      step(3);
      good(32'h0);
      ld_shd = 1'b1;
      expect_at(1, 0, 0, 1, "R8");
      step(1);
      ld_shd = 1'b0;
      step(1);

      // R1 clean complements never reset
      good(32'h0);           expect_at(1, 0, 0, 1, "R1"); step(1);
      good(32'hFFFF_FFFF);   expect_at(1, 0, 0, 1, "R1"); step(1);
      good(32'hA5C3_0F96);   expect_at(1, 0, 0, 1, "R1"); step(1);
      good(32'h0000_0001);   expect_at(1, 0, 0, 1, "R1"); step(1);

      // R1 R2 R4 mismatch in top bit of last word
      shd = ~cfg ^ 32'h8000_0000;
      expect_at(1, 1, 0, 0, "R1");
      expect_at(2, 1, 0, 0, "R2");
      expect_at(3, 1, 0, 0, "R2");
      expect_at(4, 0, 0, 0, "R2");
      expect_at(5, 0, 1, 0, "R7");
      expect_at(6, 0, 0, 0, "R7");
      expect_at(7, 0, 0, 0, "R8");
      expect_at(8, 0, 0, 0, "R8");
      step(8);
      good(32'h1234_5678);
      reload(2);

      // R3 R5 other source keeps cleared flag
      rst_src = 4'b0100;
      expect_at(1, 1, 0, 0, "R3");
      expect_at(2, 1, 0, 0, "R5");
      expect_at(3, 0, 0, 0, "R3");
      expect_at(4, 0, 1, 0, "R7");
      step(2);
      rst_src = '0;
      step(2);
      reload(0);

      // R6 software set
      flag_set = 1'b1;
      expect_at(1, 0, 0, 1, "R6");
      step(1);
      flag_set = 1'b0;

      // R5 other source keeps set flag
      rst_src = 4'b0001;
      expect_at(1, 1, 0, 1, "R5");
      expect_at(2, 0, 0, 1, "R3");
      expect_at(3, 0, 1, 1, "R7");
      step(1);
      rst_src = '0;
      step(2);
      reload(1);

      // R2 R4 mismatch at bit 0 of word 0 overlapped by a long source
      shd = ~cfg ^ 32'h0000_0001;
      rst_src = 4'b1000;
      expect_at(1, 1, 0, 0, "R4");
      for (int k = 2; k <= 5; k++) expect_at(k, 1, 0, 0, "R2");
      expect_at(6, 0, 0, 0, "R2");
      expect_at(7, 0, 1, 0, "R7");
      step(5);
      rst_src = '0;
      step(2);
      good(32'hFEDC_BA98);
      reload(0);

      // R6 mismatch wins over a simultaneous set
      flag_set = 1'b1;
      expect_at(1, 0, 0, 1, "R6");
      step(1);
      shd = ~cfg ^ 32'h0000_1000;
      expect_at(1, 1, 0, 0, "R6");
      expect_at(4, 0, 0, 0, "R2");
      expect_at(5, 0, 1, 0, "R7");
      step(1);
      flag_set = 1'b0;
      step(4);
      good(32'h0F0F_F0F0);
      reload(2);

      // R6 R9 power-on sets the flag again
      por_n = 1'b0;
      expect_at(1, 0, 0, 1, "R9");
      step(2);
      por_n = 1'b1;
      expect_at(1, 0, 1, 1, "R7");
      step(3);

      n_run++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL %s: %0d expected items left, expected 0", q[0].tag, q.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule